// File: doc/BRIEF.md
# Clock Fault Status and Interrupt Unit

This block gathers six live fault flags from a clock generator and makes them available to software: loss of signal on three reference inputs, on the crystal input and on the feedback input, plus loss of PLL lock. The fault lines arrive from other clock domains. The block synchronises them and shows them in a live status register. It also records every change of state in a sticky register that software clears bit by bit.

A per-bit mask decides which sticky bits can raise the interrupt output. The interrupt stays high until software clears the flagged sticky bits or masks them. The synchronised loss-of-lock flag also drives its own output pin, whatever the mask holds. Software reaches the registers through a flat port: an address, write data, a write strobe, and read data that follows the address combinationally.

Top module: `fault_status_unit`

## Requirements
- R1: The status register at address 0 shows the synchronised faults. Bit 0 is input 0, bit 1 is input 1, bit 2 is input 2, bit 3 is the crystal input, bit 4 is feedback and bit 5 is loss of lock. A fault input change shows in status two clock edges after it is applied.
- R2: `lol_o` follows the synchronised loss-of-lock flag with the same two-edge delay. The mask has no effect on it.
- R3: A sticky bit (address 1, same bit positions) sets on the edge after its status bit is high or after its status bit falls. A fault pulse is therefore kept in the sticky register after it has gone.
- R4: A write to address 1 clears each sticky bit whose write-data bit is 0. Sticky bits whose write-data bit is 1 keep their value.
- R5: If a status bit is high, or falls, in the same cycle as a clearing write, its sticky bit stays set.
- R6: After reset, status and sticky read 0 and the mask (address 2, same bit positions, 1 = masked) reads 0x3F. The mask can be read back and written.
- R7: `irq_o` is a register that is high one edge after any sticky bit is set while its mask bit is 0.
- R8: `irq_o` falls one edge after software clears all unmasked sticky bits or masks them.
- R9: Writes to the status address and to address 3 change no state. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| los_in_i | input | 3 | Loss of signal on reference inputs 0..2 (asynchronous) |
| los_xtal_i | input | 1 | Loss of signal on crystal input (asynchronous) |
| los_fb_i | input | 1 | Loss of signal on feedback input (asynchronous) |
| lol_i | input | 1 | PLL loss of lock (asynchronous) |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe |
| rdata_o | output | 8 | Read data for addr_i |
| irq_o | output | 1 | Interrupt, high while an unmasked sticky bit is set |
| lol_o | output | 1 | Synchronised loss of lock |

## Verification
The bench changes fault inputs and register signals only on falling clock edges and reads all outputs on falling edges. Each result has a fixed delay counted in rising edges after the stimulus:
- Status and `lol_o` are due after two rising edges.
- A sticky bit is due after three.
- `irq_o` is due after four from a fault, or after two from a mask or sticky write.
- Sticky clears and mask writes show after one.

Each scenario waits exactly that many falling edges before it reads. Interrupt timing is also checked one edge early, where the old value must still hold. Pulses are held for two cycles so that the synchroniser always captures them.

// File: rtl/fault_pkg.sv
package fault_pkg;
  localparam int NUM_FAULTS = 6;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 2;

  localparam int FLT_IN0  = 0;
  localparam int FLT_IN1  = 1;
  localparam int FLT_IN2  = 2;
  localparam int FLT_XTAL = 3;
  localparam int FLT_FB   = 4;
  localparam int FLT_LOL  = 5;

  typedef enum logic [ADDR_W-1:0] {
    REG_STATUS = 2'd0,
    REG_STICKY = 2'd1,
    REG_MASK   = 2'd2,
    REG_NONE   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/fault_sync.sv
module fault_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[0] <= '0;
        else         chain_q[0] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[s] <= '0;
        else         chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/fault_sticky.sv
module fault_sticky #(
  parameter int WIDTH = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] status_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] sticky_o
);
  logic [WIDTH-1:0] status_d_q;
  logic [WIDTH-1:0] sticky_q;
  logic [WIDTH-1:0] fell;
  logic [WIDTH-1:0] set_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_d_q <= '0;
    else         status_d_q <= status_i;
  end

  assign fell    = status_d_q & ~status_i;
  // set wins over clear
  assign set_vec = status_i | fell;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sticky_q <= '0;
    else         sticky_q <= (sticky_q & ~clr_i) | set_vec;
  end

  assign sticky_o = sticky_q;

  for (genvar g = 0; g < WIDTH; g++) begin : g_chk
    AST_STICKY_ON_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      status_i[g] |=> sticky_q[g]); // R3
    AST_STICKY_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (status_d_q[g] && !status_i[g]) |=> sticky_q[g]); // R3
    AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sticky_q[g] && !clr_i[g]) |=> sticky_q[g]); // R4
    AST_STICKY_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[g] && !status_i[g] && !status_d_q[g]) |=> !sticky_q[g]); // R4
    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[g] && status_i[g]) |=> sticky_q[g]); // R5
  end
endmodule

// File: rtl/fault_irq.sv
module fault_irq #(
  parameter int WIDTH = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] sticky_i,
  input  logic [WIDTH-1:0] mask_i,
  output logic             irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(sticky_i & ~mask_i);
  end

  assign irq_o = irq_q;

  AST_IRQ_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sticky_i & ~mask_i) != '0) |=> irq_q); // R7
  AST_IRQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sticky_i & ~mask_i) == '0) |=> !irq_q); // R8
endmodule

// File: rtl/fault_status_unit.sv
module fault_status_unit
  import fault_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        los_in_i,
  input  logic              los_xtal_i,
  input  logic              los_fb_i,
  input  logic              lol_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              lol_o
);
  logic [NUM_FAULTS-1:0] raw;
  logic [NUM_FAULTS-1:0] status;
  logic [NUM_FAULTS-1:0] sticky;
  logic [NUM_FAULTS-1:0] mask_q;
  logic [NUM_FAULTS-1:0] clr;
  logic                  wr_sticky;
  logic                  wr_mask;

  assign raw[FLT_IN0]  = los_in_i[0];
  assign raw[FLT_IN1]  = los_in_i[1];
  assign raw[FLT_IN2]  = los_in_i[2];
  assign raw[FLT_XTAL] = los_xtal_i;
  assign raw[FLT_FB]   = los_fb_i;
  assign raw[FLT_LOL]  = lol_i;

  fault_sync #(.WIDTH(NUM_FAULTS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(raw),
    .sync_o (status)
  );

  assign wr_sticky = we_i && (addr_i == REG_STICKY);
  assign wr_mask   = we_i && (addr_i == REG_MASK);
  // write-zero-to-clear
  assign clr       = wr_sticky ? ~wdata_i[NUM_FAULTS-1:0] : '0;

  fault_sticky #(.WIDTH(NUM_FAULTS)) u_sticky (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .status_i(status),
    .clr_i   (clr),
    .sticky_o(sticky)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '1;
    else if (wr_mask) mask_q <= wdata_i[NUM_FAULTS-1:0];
  end

  fault_irq #(.WIDTH(NUM_FAULTS)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sticky_i(sticky),
    .mask_i  (mask_q),
    .irq_o   (irq_o)
  );

  assign lol_o = status[FLT_LOL];

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_STATUS: rdata_o[NUM_FAULTS-1:0] = status;
      REG_STICKY: rdata_o[NUM_FAULTS-1:0] = sticky;
      REG_MASK:   rdata_o[NUM_FAULTS-1:0] = mask_q;
      default:    rdata_o = '0;
    endcase
  end

  AST_MASK_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mask |=> (mask_q == $past(wdata_i[NUM_FAULTS-1:0]))); // R6
  AST_MASK_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_mask |=> $stable(mask_q)); // R9
  AST_LOL_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lol_o) |-> $past(raw[FLT_LOL], SYNC_STAGES)); // R2
endmodule

// File: tb/tb_fault_status_unit.sv
module tb_fault_status_unit;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] los_in_i = '0;
  logic       los_xtal_i = 1'b0;
  logic       los_fb_i = 1'b0;
  logic       lol_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic       we_i = 1'b0;
  logic [7:0] rdata_o;
  logic       irq_o;
  logic       lol_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  fault_status_unit dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .los_in_i(los_in_i), .los_xtal_i(los_xtal_i),
    .los_fb_i(los_fb_i), .lol_i(lol_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .we_i(we_i), .rdata_o(rdata_o), .irq_o(irq_o), .lol_o(lol_o)
  );

  always #2 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic set_f(input logic [5:0] f);
    {lol_i, los_fb_i, los_xtal_i, los_in_i} = f;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    set_f('0); we_i = 1'b0;
    rst_ni = 1'b0;
    cyc(2);
    rst_ni = 1'b1;
    cyc(1);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset();
    rd(2'd0, d); chk("R6 status after reset", d, 8'h00);
    rd(2'd1, d); chk("R6 sticky after reset", d, 8'h00);
    rd(2'd2, d); chk("R6 mask after reset", d, 8'h3F);
    chk("R6 irq after reset", {7'd0, irq_o}, 8'h00);
  endtask

  task automatic t_status();
    logic [7:0] d;
    do_reset();
    set_f(6'b010101);
    cyc(1);
    rd(2'd0, d); chk("R1 status not yet", d, 8'h00);
    cyc(1);
    rd(2'd0, d); chk("R1 status pattern A", d, 8'h15);
    set_f(6'b001010);
    cyc(2);
    rd(2'd0, d); chk("R1 status pattern B", d, 8'h0A);
    chk("R7 irq stays low when masked", {7'd0, irq_o}, 8'h00);
  endtask

  task automatic t_lol();
    do_reset();
    set_f(6'b100000);
    cyc(1);
    chk("R2 lol_o not yet", {7'd0, lol_o}, 8'h00);
    cyc(1);
    chk("R2 lol_o high with full mask", {7'd0, lol_o}, 8'h01);
    set_f('0);
    cyc(2);
    chk("R2 lol_o low again", {7'd0, lol_o}, 8'h00);
  endtask

  task automatic t_pulse();
    logic [7:0] d;
    do_reset();
    set_f(6'b000010);
    cyc(2);
    set_f('0);
    cyc(5);
    rd(2'd0, d); chk("R3 status after pulse", d, 8'h00);
    rd(2'd1, d); chk("R3 sticky keeps pulse", d, 8'h02);
  endtask

  task automatic t_clear();
    logic [7:0] d;
    do_reset();
    set_f(6'b000011);
    cyc(2);
    set_f('0);
    cyc(5);
    wr(2'd1, 8'hFE);
    rd(2'd1, d); chk("R4 partial clear", d, 8'h02);
    wr(2'd1, 8'h00);
    rd(2'd1, d); chk("R4 full clear", d, 8'h00);
  endtask

  task automatic t_set_wins();
    logic [7:0] d;
    do_reset();
    set_f(6'b000100);
    cyc(3);
    wr(2'd1, 8'h00);
    rd(2'd1, d); chk("R5 active fault survives clear", d, 8'h04);
    set_f('0);
    cyc(4);
    wr(2'd1, 8'h00);
    rd(2'd1, d); chk("R4 clear after fault gone", d, 8'h00);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    do_reset();
    set_f(6'b010000);
    cyc(2);
    set_f('0);
    cyc(5);
    chk("R7 masked sticky no irq", {7'd0, irq_o}, 8'h00);
    wr(2'd2, 8'h2F);
    rd(2'd2, d); chk("R6 mask readback", d, 8'h2F);
    chk("R7 irq not yet after unmask", {7'd0, irq_o}, 8'h00);
    cyc(1);
    chk("R7 irq after unmask", {7'd0, irq_o}, 8'h01);
    wr(2'd2, 8'h3F);
    cyc(1);
    chk("R8 irq drops on remask", {7'd0, irq_o}, 8'h00);
  endtask

  task automatic t_irq_clear();
    do_reset();
    wr(2'd2, 8'h00);
    set_f(6'b001000);
    cyc(3);
    chk("R7 irq not before 4 edges", {7'd0, irq_o}, 8'h00);
    cyc(1);
    chk("R7 irq after fault", {7'd0, irq_o}, 8'h01);
    set_f('0);
    cyc(5);
    wr(2'd1, 8'h00);
    chk("R8 irq one edge after clear still high", {7'd0, irq_o}, 8'h01);
    cyc(1);
    chk("R8 irq low after clear", {7'd0, irq_o}, 8'h00);
  endtask

  task automatic t_ignored();
    logic [7:0] d;
    do_reset();
    wr(2'd0, 8'hFF);
    cyc(2);
    rd(2'd0, d); chk("R9 status write ignored", d, 8'h00);
    rd(2'd1, d); chk("R9 sticky untouched", d, 8'h00);
    wr(2'd3, 8'h00);
    rd(2'd3, d); chk("R9 unmapped reads zero", d, 8'h00);
    rd(2'd2, d); chk("R9 mask untouched", d, 8'h3F);
  endtask

  initial begin
    t_reset();
    t_status();
    t_lol();
    t_pulse();
    t_clear();
    t_set_wins();
    t_mask();
    t_irq_clear();
    t_ignored();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule